// File: doc/BRIEF.md
# Synchronous SRAM Read Output Pipeline Controller

This block sits between the core array of a synchronous SRAM and its bidirectional data pins. It captures each cycle's command (deselect, read or write) in an input register. It then decides when the array's read data reaches the pin bus and when the output drivers are enabled. For writes it produces the per-byte write strobes that the array uses.

Two static mode inputs shape the read path. The first selects flow-through or pipelined data. In flow-through mode the array data goes straight to the pins. In pipelined mode the data first passes through a rising-edge output register. The second mode input selects how quickly the drivers release after a deselect: either one stage sooner than read data travels, or after the same depth as read data. An output-enable input gates the drivers with no clock involved. When both mode inputs are held at zero, the block runs pipelined with the early (single-cycle) release.

Byte lanes are 9 bits wide: 8 data bits and 1 parity bit. The lane count is a parameter. Two lanes give an 18-bit bus and four lanes give a 36-bit bus.

Top module: `sram_rd_out_ctl`

## Requirements
- R1: With `flow_mode_i`=1, `dq_o` equals `rd_data_i` in the same cycle, with no register in between.
- R2: With `flow_mode_i`=0, `dq_o` shows the `rd_data_i` value sampled at the clock edge that ends the cycle in which a read was held in the input register. `dq_o` holds that value until the next read. Reset clears it to zero.
- R3: A read is a command with `sel_i`=1 and no write. It enables `drv_o` in the first cycle after its capture edge in flow-through mode. In pipelined mode it enables `drv_o` in the cycle after the following edge, which is one cycle later.
- R4: In single-cycle-deselect mode (`dcd_mode_i`=0), pipelined, `drv_o` goes low in the cycle right after a deselect (`sel_i`=0) is captured, even when the previous read's data is still in the output register.
- R5: In dual-cycle-deselect mode (`dcd_mode_i`=1), pipelined, a deselect that follows a read keeps `drv_o` high for one more cycle. `drv_o` drops only after the second edge.
- R6: `out_en_i`=0 forces `drv_o` low immediately, without a clock edge. Restoring `out_en_i` restores the driven state within the same cycle.
- R7: `sel_i`=1, `gw_i`=0, `bw_i`=1 with at least one `bsel_i` bit set is a byte write. In the cycle after capture, `wr_be_o` equals `bsel_i` (bit n enables lane n, bits [9n+8:9n]). Otherwise `wr_be_o` is zero.
- R8: `sel_i`=1 with `gw_i`=1 is a write of every lane. `wr_be_o` is all ones regardless of `bw_i` and `bsel_i`.
- R9: `sel_i`=1 with `bw_i`=1 but no `bsel_i` bit set (and `gw_i`=0) is treated as a read. It drives the bus with read timing and produces no strobes.
- R10: With both mode inputs at 0, the block uses pipelined read latency and single-cycle deselect.
- R11: A read that directly follows a deselect enables the drivers again with the normal read latency of the active mode.
- R12: `drv_o` is low in every cycle in which a write is held in the input register, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Chip select; 0 is a deselect command |
| gw_i | input | 1 | Write of all lanes |
| bw_i | input | 1 | Byte-write enable |
| bsel_i | input | LANES | Per-lane byte select |
| flow_mode_i | input | 1 | 1: flow-through, 0: pipelined |
| dcd_mode_i | input | 1 | 1: dual-cycle deselect, 0: single-cycle |
| out_en_i | input | 1 | Output enable, asynchronous, active high |
| rd_data_i | input | LANES*9 | Array read data for the command in the input register |
| dq_o | output | LANES*9 | Value presented to the pin drivers |
| drv_o | output | 1 | Pin driver enable |
| wr_be_o | output | LANES | Per-lane write strobes |

## Verification
The bench focuses on command transitions. It covers read to deselect in both deselect modes, deselect to read, and read to write. A design that confused the two deselect modes would release the bus one cycle early or late. A design that let the output register keep control during a write would collide with the writer's data. The degenerate byte write with no lanes selected is exercised, since a design that treats it as a write would float the bus and emit empty strobes. The output enable is toggled in the middle of a cycle, to catch a design that registers it.

// File: rtl/sram_rd_out_pkg.sv
package sram_rd_out_pkg;
  localparam int unsigned LANE_BITS = 9;

  typedef enum logic [1:0] {
    CMD_IDLE = 2'd0,
    CMD_RD   = 2'd1,
    CMD_WR   = 2'd2
  } cmd_e;
endpackage

// File: rtl/srpc_cmd_reg.sv
module srpc_cmd_reg
  import sram_rd_out_pkg::*;
#(
  parameter int unsigned LANES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             gw_i,
  input  logic             bw_i,
  input  logic [LANES-1:0] bsel_i,
  output cmd_e             cmd_q_o,
  output logic [LANES-1:0] be_q_o
);
  logic [LANES-1:0] lane_wr;
  logic             wr_req;
  cmd_e             cmd_d;
  cmd_e             cmd_q;
  logic [LANES-1:0] be_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_wr[g] = gw_i | (bw_i & bsel_i[g]);
  end

  // byte write with no lane selected degrades to a read
  assign wr_req = sel_i & (|lane_wr);

  always_comb begin
    if (!sel_i)      cmd_d = CMD_IDLE;
    else if (wr_req) cmd_d = CMD_WR;
    else             cmd_d = CMD_RD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= CMD_IDLE;
      be_q  <= '0;
    end else begin
      cmd_q <= cmd_d;
      be_q  <= wr_req ? lane_wr : '0;
    end
  end

  assign cmd_q_o = cmd_q;
  assign be_q_o  = be_q;
endmodule

// File: rtl/srpc_data_stage.sv
module srpc_data_stage
  import sram_rd_out_pkg::*;
#(
  parameter int unsigned DW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cmd_e          cmd_q_i,
  input  logic          flow_mode_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [DW-1:0] dq_o,
  output logic          rd_vld_o
);
  logic [DW-1:0] dq_q;
  logic          rd_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dq_q     <= '0;
      rd_vld_q <= 1'b0;
    end else begin
      rd_vld_q <= (cmd_q_i == CMD_RD);
      if (cmd_q_i == CMD_RD) dq_q <= rd_data_i;
    end
  end

  assign dq_o     = flow_mode_i ? rd_data_i : dq_q;
  assign rd_vld_o = rd_vld_q;
endmodule

// File: rtl/srpc_drv_ctl.sv
module srpc_drv_ctl
  import sram_rd_out_pkg::*;
(
  input  cmd_e cmd_q_i,
  input  logic rd_vld_i,
  input  logic flow_mode_i,
  input  logic dcd_mode_i,
  input  logic out_en_i,
  output logic drv_o
);
  logic in_rd, in_wr, in_idle, pipe_drv, sync_drv;

  assign in_rd   = (cmd_q_i == CMD_RD);
  assign in_wr   = (cmd_q_i == CMD_WR);
  assign in_idle = (cmd_q_i == CMD_IDLE);

  // single-cycle deselect cuts the output stage as soon as the deselect lands
  assign pipe_drv = rd_vld_i & ~in_wr & (dcd_mode_i | ~in_idle);
  assign sync_drv = flow_mode_i ? in_rd : pipe_drv;
  assign drv_o    = out_en_i & sync_drv;
endmodule

// File: rtl/sram_rd_out_ctl.sv
module sram_rd_out_ctl
  import sram_rd_out_pkg::*;
#(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = LANE_BITS
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sel_i,
  input  logic                    gw_i,
  input  logic                    bw_i,
  input  logic [LANES-1:0]        bsel_i,
  input  logic                    flow_mode_i,
  input  logic                    dcd_mode_i,
  input  logic                    out_en_i,
  input  logic [LANES*LANE_W-1:0] rd_data_i,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic                    drv_o,
  output logic [LANES-1:0]        wr_be_o
);
  localparam int unsigned DW = LANES * LANE_W;

  cmd_e cmd_q;
  logic rd_vld;

  srpc_cmd_reg #(.LANES(LANES)) u_cmd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel_i),
    .gw_i    (gw_i),
    .bw_i    (bw_i),
    .bsel_i  (bsel_i),
    .cmd_q_o (cmd_q),
    .be_q_o  (wr_be_o)
  );

  srpc_data_stage #(.DW(DW)) u_data (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_q_i     (cmd_q),
    .flow_mode_i (flow_mode_i),
    .rd_data_i   (rd_data_i),
    .dq_o        (dq_o),
    .rd_vld_o    (rd_vld)
  );

  srpc_drv_ctl u_drv (
    .cmd_q_i     (cmd_q),
    .rd_vld_i    (rd_vld),
    .flow_mode_i (flow_mode_i),
    .dcd_mode_i  (dcd_mode_i),
    .out_en_i    (out_en_i),
    .drv_o       (drv_o)
  );
endmodule

// File: rtl/sram_rd_out_ctl_chk.sv
module sram_rd_out_ctl_chk #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 9
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    sel_i,
  input logic                    gw_i,
  input logic                    bw_i,
  input logic [LANES-1:0]        bsel_i,
  input logic                    flow_mode_i,
  input logic                    dcd_mode_i,
  input logic                    out_en_i,
  input logic [LANES*LANE_W-1:0] rd_data_i,
  input logic [LANES*LANE_W-1:0] dq_o,
  input logic                    drv_o,
  input logic [LANES-1:0]        wr_be_o
);
  logic       wr_req, rd_req;
  logic [1:0] since_rst;

  assign wr_req = sel_i & (gw_i | (bw_i & (|bsel_i)));
  assign rd_req = sel_i & ~wr_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  p_flow_data_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flow_mode_i |-> dq_o == rd_data_i);

  p_pipe_data_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 2'd2 && !flow_mode_i && $past(rd_req, 2)) |-> dq_o == $past(rd_data_i));

  p_flow_drv_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 2'd1 && flow_mode_i && drv_o) |-> $past(rd_req));

  p_scd_cut_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 2'd2 && !flow_mode_i && !dcd_mode_i && drv_o) |->
      ($past(rd_req, 2) && $past(rd_req)));

  p_dcd_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 2'd2 && !flow_mode_i && dcd_mode_i && out_en_i &&
     $past(rd_req, 2) && !$past(wr_req)) |-> drv_o);

  p_oe_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_i |-> !drv_o);

  p_byte_be_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 2'd1 && $past(sel_i && !gw_i && bw_i)) |-> wr_be_o == $past(bsel_i));

  p_glob_be_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 2'd1 && $past(sel_i && gw_i)) |-> (&wr_be_o));

  p_wr_no_drv_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_be_o) |-> !drv_o);
endmodule

bind sram_rd_out_ctl sram_rd_out_ctl_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/tb_sram_rd_out_ctl.sv
module tb_sram_rd_out_ctl;
  localparam int unsigned LANES  = 2;
  localparam int unsigned LANE_W = 9;
  localparam int unsigned DW     = LANES * LANE_W;
  localparam time         PERIOD = 10ns;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             sel_i = 1'b0, gw_i = 1'b0, bw_i = 1'b0;
  logic [LANES-1:0] bsel_i = '0;
  logic             flow_mode_i = 1'b0, dcd_mode_i = 1'b0, out_en_i = 1'b1;
  logic [DW-1:0]    rd_data_i = '0;
  logic [DW-1:0]    dq_o;
  logic             drv_o;
  logic [LANES-1:0] wr_be_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state
  bit               m_rd = 0, m_wr = 0, m_rdv = 0;
  logic [DW-1:0]    m_dq = '0;
  logic [LANES-1:0] m_be = '0;

  sram_rd_out_ctl #(.LANES(LANES), .LANE_W(LANE_W)) dut (.*);

  always #(PERIOD/2) clk_i = ~clk_i;

  function automatic logic [LANES-1:0] exp_strobe(bit s, bit g, bit b, logic [LANES-1:0] bs);
    if (!s)     return '0;
    if (g)      return '1;
    if (b)      return bs;
    return '0;
  endfunction

  function automatic bit exp_drive(bit oe, bit fl, bit dc);
    bit idle = !m_rd && !m_wr;
    if (!oe) return 0;
    if (fl)  return m_rd;
    return m_rdv && !m_wr && (dc || !idle);
  endfunction

  task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(bit s, bit g, bit b, logic [LANES-1:0] bs, bit oe, bit fl, bit dc,
                     string ovr, bit probe);
    logic [DW-1:0]    d;
    logic [LANES-1:0] st;
    bit               ed;
    string            t;
    @(negedge clk_i);
    d = DW'({$urandom, $urandom});
    sel_i = s; gw_i = g; bw_i = b; bsel_i = bs;
    out_en_i = oe; flow_mode_i = fl; dcd_mode_i = dc; rd_data_i = d;
    #1;
    ed = exp_drive(oe, fl, dc);
    if (!oe)                 t = "R6";
    else if (m_wr)           t = "R12";
    else if (fl)             t = "R3";
    else if (!m_rd && !m_wr) t = dc ? "R5" : "R4";
    else                     t = "R3";
    if (ovr != "") t = ovr;
    chk(t, "drv", DW'(drv_o), DW'(ed));
    chk(ovr != "" ? ovr : (fl ? "R1" : "R2"), "dq", dq_o, fl ? d : m_dq);
    chk(ovr != "" ? ovr : "R7_R8", "be", DW'(wr_be_o), DW'(m_be));
    if (probe) begin
      out_en_i = 1'b0;
      #1 chk("R6", "drv_async_off", DW'(drv_o), '0);
      out_en_i = oe;
      #1 chk("R6", "drv_async_on", DW'(drv_o), DW'(ed));
    end
    @(posedge clk_i);
    st = exp_strobe(s, g, b, bs);
    if (m_rd) m_dq = d;
    m_rdv = m_rd;
    m_wr  = (st != '0);
    m_rd  = s && !m_wr;
    m_be  = st;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit fl, dc;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk_i);
    #1;
    chk("R2", "reset_dq", dq_o, '0);
    chk("R12", "reset_drv", DW'(drv_o), '0);
    chk("R7", "reset_be", DW'(wr_be_o), '0);
    @(negedge clk_i) rst_ni = 1'b1;

    // defaults: pipelined, single-cycle deselect
    cyc(1, 0, 0, '0, 1, 0, 0, "R10", 0);
    cyc(0, 0, 0, '0, 1, 0, 0, "R10", 0);
    cyc(0, 0, 0, '0, 1, 0, 0, "R10", 0);
    // deselect between reads, both latencies
    cyc(1, 0, 0, '0, 1, 0, 0, "R11", 0);
    cyc(0, 0, 0, '0, 1, 0, 0, "R11", 0);
    cyc(1, 0, 0, '0, 1, 0, 0, "R11", 0);
    cyc(0, 0, 0, '0, 1, 0, 0, "R11", 0);
    cyc(0, 0, 0, '0, 1, 0, 0, "R11", 0);
    cyc(1, 0, 0, '0, 1, 1, 0, "R11", 0);
    cyc(0, 0, 0, '0, 1, 1, 0, "R11", 0);
    cyc(1, 0, 0, '0, 1, 1, 0, "R11", 0);
    cyc(0, 0, 0, '0, 1, 1, 0, "R11", 0);
    // dual-cycle deselect hold, then read followed by write
    cyc(1, 0, 0, '0, 1, 0, 1, "", 0);
    cyc(0, 0, 0, '0, 1, 0, 1, "", 0);
    cyc(0, 0, 0, '0, 1, 0, 1, "R5", 0);
    cyc(0, 0, 0, '0, 1, 0, 1, "R5", 0);
    cyc(1, 0, 0, '0, 1, 0, 1, "", 0);
    cyc(1, 0, 1, 2'b01, 1, 0, 1, "", 0);
    cyc(0, 0, 0, '0, 1, 0, 1, "R12", 0);
    // byte write with no lanes acts as a read
    cyc(1, 0, 1, 2'b00, 1, 0, 0, "R9", 0);
    cyc(1, 0, 1, 2'b00, 1, 0, 0, "R9", 0);
    cyc(0, 0, 0, '0, 1, 0, 0, "R9", 0);
    // global write overrides byte controls
    cyc(1, 1, 0, 2'b00, 1, 0, 0, "R8", 0);
    cyc(1, 1, 1, 2'b10, 1, 0, 0, "R8", 0);
    cyc(0, 0, 0, '0, 1, 0, 0, "R8", 0);
    // byte writes per lane
    cyc(1, 0, 1, 2'b10, 1, 0, 0, "R7", 0);
    cyc(0, 0, 0, '0, 1, 0, 0, "R7", 0);
    // async output enable
    cyc(1, 0, 0, '0, 1, 0, 0, "", 0);
    cyc(1, 0, 0, '0, 1, 0, 0, "", 1);
    cyc(0, 0, 0, '0, 1, 1, 0, "", 0);
    cyc(1, 0, 0, '0, 1, 1, 0, "", 1);

    fl = 0; dc = 0;
    for (int i = 0; i < 3000; i++) begin
      if (i % 40 == 0) begin
        fl = $urandom_range(0, 1) != 0;
        dc = $urandom_range(0, 1) != 0;
      end
      cyc($urandom_range(0, 9) < 7, $urandom_range(0, 9) < 1, $urandom_range(0, 9) < 3,
          LANES'($urandom), $urandom_range(0, 9) < 9, fl, dc, "", $urandom_range(0, 31) == 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule